// File: doc/BRIEF.md
# Multiplexed Local Bus Master

This block turns single 32-bit register requests from a host-side port into transfers on a narrow bus that links two chips. Address and data share one 16-bit bidirectional path. Each access begins with a one-clock address cycle. Two 16-bit data halves follow, and the slave paces each half with an active-low ready line. The master marks the second half with an active-low last-cycle flag.

The host presents an address, a direction bit and a write word, and pulses a request strobe while the block is idle. A one-cycle done pulse reports completion. For a read, the done cycle also carries the assembled 32-bit word. The shared bus is modelled as three signals: an input, an output and an output enable. The tristate buffer is left to the pad level.

Top module: `lbus_master`

## Requirements
- R1: After reset the address strobe and last-cycle flag are high, the output enable is low, and done and busy are low.
- R2: A request seen on a clock edge while idle produces, in the next cycle, an address phase exactly one cycle long. In that cycle the address strobe is low, the bus output carries the address and the output enable is high.
- R3: During the address phase the direction line is 1 for a write and 0 for a read.
- R4: Two data phases follow the address phase. In a write, the first phase drives bits 15:0 of the word and the second drives bits 31:16, with the output enable high.
- R5: A data phase ends only on a clock edge where ready is low. Until then the phase and every bus output stay unchanged.
- R6: The last-cycle flag is low throughout the second data phase and high at all other times.
- R7: In a read, the output enable is low during both data phases. The bus input is captured on each ready edge: the first half becomes bits 15:0 of the read word and the second half becomes bits 31:16.
- R8: Done is high for exactly one cycle, the cycle after the second data phase completes. In that cycle busy is low and, for a read, the read word holds the assembled value.
- R9: A request strobe that arrives while busy is ignored and produces no further address phase.
- R10: Asserting reset in the middle of a transfer returns all bus outputs to the idle state of R1 at once. A later request is then handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 32 | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read word |
| busy | output | 1 | Transfer in progress |
| bus_ads_n | output | 1 | Active-low address strobe |
| bus_wr | output | 1 | Direction line |
| bus_last_n | output | 1 | Active-low last-cycle flag |
| bus_rdy_n | input | 1 | Active-low slave ready |
| bus_ad_i | input | 16 | Shared bus, inbound |
| bus_ad_o | output | 16 | Shared bus, outbound |
| bus_ad_oe | output | 1 | Shared bus output enable |

## Verification
The address phase appears one cycle after the edge that accepts the request. Each data half is present from the start of its phase until the first edge where ready is low. Done and the read word appear one cycle after the final ready edge. The bench drives inputs and samples outputs at the falling edge. It counts these cycles itself as it runs the slave handshake, so every check falls in the cycle where its result is due. It also checks that the outputs stay unchanged through each wait cycle.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  typedef enum logic [1:0] {
    LB_IDLE = 2'd0,
    LB_ADDR = 2'd1,
    LB_DATA = 2'd2
  } lb_state_e;

endpackage

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
#(
  parameter int NHALF = 2,
  localparam int PH_W = (NHALF > 1) ? $clog2(NHALF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            rdy_n,
  output lb_state_e       state,
  output logic [PH_W-1:0] phase,
  output logic            accept,
  output logic            beat_done,
  output logic            last_beat,
  output logic            done
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NHALF - 1);

  lb_state_e       state_q;
  logic [PH_W-1:0] phase_q;
  logic            done_q;

  assign accept    = (state_q == LB_IDLE) && req_valid;
  assign last_beat = (state_q == LB_DATA) && (phase_q == LAST_PH);
  assign beat_done = (state_q == LB_DATA) && !rdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LB_IDLE;
      phase_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= beat_done && last_beat;
      unique case (state_q)
        LB_IDLE: if (accept) state_q <= LB_ADDR;
        LB_ADDR: begin
          state_q <= LB_DATA;
          phase_q <= '0;
        end
        LB_DATA: if (beat_done) begin
          if (phase_q == LAST_PH) begin
            state_q <= LB_IDLE;
            phase_q <= '0;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
        default: state_q <= LB_IDLE;
      endcase
    end
  end

  assign state = state_q;
  assign phase = phase_q;
  assign done  = done_q;

endmodule

// File: rtl/lbus_wpath.sv
module lbus_wpath
  import lbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16,
  parameter int WORD_W = 32,
  localparam int NHALF = WORD_W / BUS_W,
  localparam int PH_W  = (NHALF > 1) ? $clog2(NHALF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  lb_state_e         state,
  input  logic [PH_W-1:0]   phase,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ad_oe,
  output logic              wr
);

  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  function automatic logic [BUS_W-1:0] slice_half(input logic [WORD_W-1:0] w,
                                                  input logic [PH_W-1:0] idx);
    return w[int'(idx)*BUS_W +: BUS_W];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    ad_o  = '0;
    ad_oe = 1'b0;
    if (state == LB_ADDR) begin
      ad_o  = BUS_W'(addr_q);
      ad_oe = 1'b1;
    end else if (state == LB_DATA && wr_q) begin
      ad_o  = slice_half(wdata_q, phase);
      ad_oe = 1'b1;
    end
  end

  assign wr = wr_q;

endmodule

// File: rtl/lbus_rpath.sv
module lbus_rpath #(
  parameter int BUS_W  = 16,
  parameter int WORD_W = 32,
  localparam int NHALF = WORD_W / BUS_W,
  localparam int PH_W  = (NHALF > 1) ? $clog2(NHALF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [PH_W-1:0]   phase,
  input  logic [BUS_W-1:0]  ad_i,
  output logic [WORD_W-1:0] rdata
);

  for (genvar g = 0; g < NHALF; g++) begin : g_lane
    logic [BUS_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              lane_q <= '0;
      else if (capture && phase == PH_W'(g))   lane_q <= ad_i;
    end
    assign rdata[g*BUS_W +: BUS_W] = lane_q;
  end

endmodule

// File: rtl/lbus_master.sv
module lbus_master
  import lbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16,
  parameter int WORD_W = 32,
  localparam int NHALF = WORD_W / BUS_W,
  localparam int PH_W  = (NHALF > 1) ? $clog2(NHALF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              bus_ads_n,
  output logic              bus_wr,
  output logic              bus_last_n,
  input  logic              bus_rdy_n,
  input  logic [BUS_W-1:0]  bus_ad_i,
  output logic [BUS_W-1:0]  bus_ad_o,
  output logic              bus_ad_oe
);

  lb_state_e       state;
  logic [PH_W-1:0] phase;
  logic            accept;
  logic            beat_done;
  logic            last_beat;
  logic            in_data;
  logic            rd_capture;

  lbus_seq #(.NHALF(NHALF)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rdy_n     (bus_rdy_n),
    .state     (state),
    .phase     (phase),
    .accept    (accept),
    .beat_done (beat_done),
    .last_beat (last_beat),
    .done      (rsp_done)
  );

  lbus_wpath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .WORD_W(WORD_W)) u_wpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state     (state),
    .phase     (phase),
    .ad_o      (bus_ad_o),
    .ad_oe     (bus_ad_oe),
    .wr        (bus_wr)
  );

  assign in_data    = (state == LB_DATA);
  assign rd_capture = beat_done && !bus_wr;

  lbus_rpath #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_rpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (rd_capture),
    .phase   (phase),
    .ad_i    (bus_ad_i),
    .rdata   (rsp_rdata)
  );

  assign busy       = (state != LB_IDLE);
  assign bus_ads_n  = !(state == LB_ADDR);
  assign bus_last_n = !last_beat;

endmodule

// File: rtl/lbus_master_chk.sv
module lbus_master_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_ads_n,
  input logic             bus_last_n,
  input logic             bus_rdy_n,
  input logic             bus_ad_oe,
  input logic [BUS_W-1:0] bus_ad_o,
  input logic             rsp_done,
  input logic             busy,
  input logic             in_data
);

  p_ads_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ads_n |=> bus_ads_n);

  p_ads_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ads_n |-> bus_ad_oe);

  p_hold_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && bus_rdy_n) |=> (in_data && $stable(bus_last_n) && $stable(bus_ad_o)));

  p_last_in_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_last_n |-> in_data);

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($past(!bus_last_n && !bus_rdy_n) && !busy));

  p_ads_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ads_n |-> $past(!busy));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_ads_n && bus_last_n && !bus_ad_oe));

endmodule

bind lbus_master lbus_master_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_ads_n  (bus_ads_n),
  .bus_last_n (bus_last_n),
  .bus_rdy_n  (bus_rdy_n),
  .bus_ad_oe  (bus_ad_oe),
  .bus_ad_o   (bus_ad_o),
  .rsp_done   (rsp_done),
  .busy       (busy),
  .in_data    (in_data)
);

// File: tb/lbus_master_test.sv
`timescale 1ns/1ps
module lbus_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        busy;
  logic        bus_ads_n;
  logic        bus_wr;
  logic        bus_last_n;
  logic        bus_rdy_n = 1'b1;
  logic [15:0] bus_ad_i = 16'hDEAD;
  logic [15:0] bus_ad_o;
  logic        bus_ad_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lbus_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .busy(busy), .bus_ads_n(bus_ads_n), .bus_wr(bus_wr),
    .bus_last_n(bus_last_n), .bus_rdy_n(bus_rdy_n), .bus_ad_i(bus_ad_i),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe)
  );

  // {write, addr, wdata, slave read word, wait0, wait1}
  localparam int NV = 6;
  localparam logic [88:0] VEC [NV] = '{
    {1'b1, 16'h1800, 32'h8BADF00D, 32'h00000000, 4'd0, 4'd0},
    {1'b0, 16'h1800, 32'h00000000, 32'h8BADF00D, 4'd0, 4'd0},
    {1'b1, 16'h0042, 32'h12345678, 32'h00000000, 4'd2, 4'd1},
    {1'b0, 16'hFFFE, 32'h00000000, 32'hCAFE0BEE, 4'd3, 4'd0},
    {1'b0, 16'h0001, 32'h00000000, 32'hFFFF0001, 4'd0, 4'd2},
    {1'b1, 16'hA5A5, 32'h0000FFFF, 32'h00000000, 4'd1, 4'd1}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle_chk(input string rq);
    chk(bus_ads_n == 1'b1, rq, 32'(bus_ads_n), 32'd1);
    chk(bus_last_n == 1'b1, rq, 32'(bus_last_n), 32'd1);
    chk(bus_ad_oe == 1'b0, rq, 32'(bus_ad_oe), 32'd0);
    chk(rsp_done == 1'b0, rq, 32'(rsp_done), 32'd0);
    chk(busy == 1'b0, rq, 32'(busy), 32'd0);
  endtask

  task automatic phase_chk(input bit wr, input int h, input logic [31:0] wd);
    logic [15:0] half;
    half = (h == 0) ? wd[15:0] : wd[31:16];
    chk(bus_ads_n == 1'b1, "R2", 32'(bus_ads_n), 32'd1);
    chk(bus_last_n == ((h == 1) ? 1'b0 : 1'b1), "R6", 32'(bus_last_n), 32'((h == 1) ? 0 : 1));
    chk(rsp_done == 1'b0, "R8", 32'(rsp_done), 32'd0);
    if (wr) begin
      chk(bus_ad_oe == 1'b1, "R4", 32'(bus_ad_oe), 32'd1);
      chk(bus_ad_o == half, "R4", 32'(bus_ad_o), 32'(half));
    end else begin
      chk(bus_ad_oe == 1'b0, "R7", 32'(bus_ad_oe), 32'd0);
    end
  endtask

  // Called at a falling edge with the block idle; returns at a falling edge, idle.
  task automatic xfer(input bit wr, input logic [15:0] addr, input logic [31:0] wd,
                      input logic [31:0] rd, input int w0, input int w1, input bit inject);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 16'h0BAD; req_wdata = 32'hBADBADBA;
    chk(bus_ads_n == 1'b0, "R2", 32'(bus_ads_n), 32'd0);
    chk(bus_ad_o == addr, "R2", 32'(bus_ad_o), 32'(addr));
    chk(bus_ad_oe == 1'b1, "R2", 32'(bus_ad_oe), 32'd1);
    chk(bus_wr == wr, "R3", 32'(bus_wr), 32'(wr));
    chk(bus_last_n == 1'b1, "R6", 32'(bus_last_n), 32'd1);
    @(negedge clk);
    for (int h = 0; h < 2; h++) begin
      int w;
      w = (h == 0) ? w0 : w1;
      for (int i = 0; i < w; i++) begin
        phase_chk(wr, h, wd);
        bus_rdy_n = 1'b1;
        bus_ad_i  = 16'h5A5A;
        if (inject && h == 0 && i == 0) begin
          req_valid = 1'b1; req_write = ~wr; req_addr = 16'h7777;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_ads_n == 1'b1, "R9", 32'(bus_ads_n), 32'd1);
      end
      phase_chk(wr, h, wd);
      bus_rdy_n = 1'b0;
      bus_ad_i  = (h == 0) ? rd[15:0] : rd[31:16];
      @(negedge clk);
      bus_rdy_n = 1'b1;
      bus_ad_i  = 16'hDEAD;
    end
    chk(rsp_done == 1'b1, "R8", 32'(rsp_done), 32'd1);
    chk(busy == 1'b0, "R8", 32'(busy), 32'd0);
    chk(bus_last_n == 1'b1, "R6", 32'(bus_last_n), 32'd1);
    if (!wr) chk(rsp_rdata == rd, "R7", rsp_rdata, rd);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R8", 32'(rsp_done), 32'd0);
    chk(bus_ads_n == 1'b1, "R9", 32'(bus_ads_n), 32'd1);
    @(negedge clk);
    chk(bus_ads_n == 1'b1, "R9", 32'(bus_ads_n), 32'd1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    idle_chk("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1");

    for (int k = 0; k < NV; k++) begin
      logic [88:0] v;
      v = VEC[k];
      xfer(v[88], v[87:72], v[71:40], v[39:8], int'(v[7:4]), int'(v[3:0]), 1'b0);
    end

    // R9: a request during a wait cycle is ignored
    xfer(1'b0, 16'h3030, 32'h0, 32'h13579BDF, 2, 1, 1'b1);
    xfer(1'b1, 16'h3131, 32'hFEDCBA98, 32'h0, 1, 0, 1'b1);

    // R10: reset in the middle of a transfer
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h4444; req_wdata = 32'h11112222;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_chk("R10");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R10");
    xfer(1'b0, 16'h4545, 32'h0, 32'h600DCAFE, 1, 1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule